// File: doc/BRIEF.md
# Three-Stage Pipeline Hazard Controller

This block steers an in-order integer pipeline with three stages. The front stage fetches, decodes and reads registers. The middle stage executes. The back stage accesses data memory and writes the register file at the end of its cycle. There is no forwarding path. A register read therefore waits until the producing instruction has written its result.

The controller tracks the destination of every instruction in flight. It compares the two sources of the decoding instruction against the middle and back stages and holds the front stage for as few cycles as that rule allows. Branches and jumps are predicted not taken. When the execute stage reports a redirect, the controller loads the target into the PC for the next cycle, discards the wrong-path instruction, and lets this override any stall. A parameter states whether the register file passes a same-cycle write through to the read port. The datapath, decoder and memories are outside the block.

Top module: `pipe3_hazard_ctrl`

## Requirements
- R1: After reset, `pc` equals `RESET_VEC`, `ex_valid` is 0 and `wb_we` is 0.
- R2: When there is no stall and no redirect, `pc` advances by 4 in the next cycle and `pc_sel` is 0 (sequential; 1 = hold, 2 = redirect).
- R3: `fd_stall` rises when a used, nonzero source equals the destination of a valid, writing instruction in execute.
- R4: With `WB_BYPASS`=0, a used nonzero source that matches a valid writing instruction in write-back also stalls. With `WB_BYPASS`=1 that match does not stall.
- R5: A source whose used flag is 0, or whose index is 0, never causes a stall, even when an in-flight destination matches it.
- R6: During a stall `pc` holds, `pc_sel` is 1, and `ex_valid` is 0 in the next cycle. A dependency on execute costs exactly two stall cycles and one on write-back exactly one (`WB_BYPASS`=0).
- R7: If `ex_redirect` is high while `ex_valid` is 1, then `fd_flush` is 1 and `pc_sel` is 2. The next `pc` equals `ex_target`, the next `ex_valid` is 0, and the destination of the discarded instruction never causes a stall.
- R8: A redirect overrides a stall: `fd_stall` is 0 whenever `fd_flush` is 1.
- R9: `ex_redirect` is ignored while `ex_valid` is 0: no flush occurs and `pc` advances sequentially.
- R10: An instruction reaches write-back one cycle after execute. `wb_we` is 1 only for a valid writing instruction with a nonzero destination, and `wb_rd` then carries that destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fd_rs1 | input | RIDX_W | First source index of the decoding instruction |
| fd_rs1_used | input | 1 | Decoding instruction reads its first source |
| fd_rs2 | input | RIDX_W | Second source index of the decoding instruction |
| fd_rs2_used | input | 1 | Decoding instruction reads its second source |
| fd_rd | input | RIDX_W | Destination index of the decoding instruction |
| fd_rd_we | input | 1 | Decoding instruction writes its destination |
| ex_redirect | input | 1 | Execute resolved a taken branch or a jump |
| ex_target | input | XLEN | Redirect target address from execute |
| pc | output | XLEN | Fetch address of the current cycle |
| pc_sel | output | 2 | Next-PC choice: 0 sequential, 1 hold, 2 redirect |
| fd_stall | output | 1 | Hold the PC and the front-stage instruction |
| fd_flush | output | 1 | Discard the front-stage instruction |
| ex_valid | output | 1 | Execute holds a live instruction |
| wb_we | output | 1 | Register file write enable from write-back |
| wb_rd | output | RIDX_W | Register file write index from write-back |

## Verification
The instruction stream covers several cases. Producers sit one and then two slots ahead of a consumer, which separates the two-cycle stall for an execute dependency from the one-cycle stall for a write-back dependency. A second instance with write-back bypass shows where the two parameter settings differ. Matching indices are presented with the used flags cleared, and destinations of x0 are placed in flight, to show that neither triggers a hold. Redirects are raised while a dependency is pending, while execute holds a flushed bubble, and ahead of a wrong-path producer, to show flush priority, qualification by a valid execute slot, and that discarded writes are forgotten.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;

    // Next-PC choice; encoding is visible on the pc_sel port
    typedef enum logic [1:0] {
        PC_SEQ   = 2'd0,
        PC_HOLD  = 2'd1,
        PC_REDIR = 2'd2
    } pc_sel_e;

    // Number of register sources compared per decoding instruction
    localparam int unsigned NSRC = 2;

endpackage

// File: rtl/p3_src_hazard.sv
module p3_src_hazard #(
    parameter int unsigned RIDX_W    = 5,
    parameter bit          WB_BYPASS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] rs,
    input  logic              rs_used,
    input  logic              ex_v,
    input  logic [RIDX_W-1:0] ex_rd,
    input  logic              ex_we,
    input  logic              mw_v,
    input  logic [RIDX_W-1:0] mw_rd,
    input  logic              mw_we,
    output logic              hit
);

    logic live_src;
    logic ex_match;
    logic mw_match;

    always_comb begin
        live_src = rs_used && (rs != '0);
        ex_match = ex_v && ex_we && (ex_rd == rs);
        mw_match = mw_v && mw_we && (mw_rd == rs);
    end

    generate
        if (WB_BYPASS) begin : g_byp
            // register file hands a same-cycle write to the reader
            assign hit = live_src && ex_match;
        end else begin : g_nobyp
            assign hit = live_src && (ex_match || mw_match);
        end
    endgenerate

    // R5
    idle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rs_used || rs == '0) |-> !hit);

endmodule

// File: rtl/p3_stage_track.sv
module p3_stage_track #(
    parameter int unsigned RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_v,
    input  logic [RIDX_W-1:0] issue_rd,
    input  logic              issue_we,
    output logic              ex_v,
    output logic [RIDX_W-1:0] ex_rd,
    output logic              ex_we,
    output logic              mw_v,
    output logic [RIDX_W-1:0] mw_rd,
    output logic              mw_we
);

    typedef struct packed {
        logic              v;
        logic [RIDX_W-1:0] rd;
        logic              we;
    } slot_t;

    typedef struct packed {
        slot_t ex;
        slot_t mw;
    } track_t;

    localparam track_t TRACK_RST = '0;

    track_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.mw    = st_q.ex;
        st_d.ex.v  = issue_v;
        st_d.ex.rd = issue_v ? issue_rd : '0;
        st_d.ex.we = issue_v && issue_we;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TRACK_RST;
        else        st_q <= st_d;
    end

    assign ex_v  = st_q.ex.v;
    assign ex_rd = st_q.ex.rd;
    assign ex_we = st_q.ex.we;
    assign mw_v  = st_q.mw.v;
    assign mw_rd = st_q.mw.rd;
    assign mw_we = st_q.mw.we;

    // R10
    ex_to_mw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mw_v == $past(ex_v)) && (mw_rd == $past(ex_rd)) && (mw_we == $past(ex_we)));

    // R6
    bubble_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_v |=> !ex_v);

endmodule

// File: rtl/p3_pc_unit.sv
module p3_pc_unit
    import pipe3_pkg::*;
#(
    parameter int unsigned       XLEN      = 32,
    parameter logic [XLEN-1:0]   RESET_VEC = 32'h0000_1000,
    parameter int unsigned       STEP      = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pc_sel_e         sel,
    input  logic [XLEN-1:0] target,
    output logic [XLEN-1:0] pc
);

    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } pc_state_t;

    pc_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (sel)
            PC_REDIR: s_d.pc = target;
            PC_HOLD:  s_d.pc = s_q.pc;
            default:  s_d.pc = s_q.pc + STEP_V;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.pc <= RESET_VEC;
        else        s_q    <= s_d;
    end

    assign pc = s_q.pc;

    // R6
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == PC_HOLD) |=> pc == $past(pc));

    // R7
    pc_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == PC_REDIR) |=> pc == $past(target));

    // R2
    pc_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == PC_SEQ) |=> pc == $past(pc) + STEP_V);

endmodule

// File: rtl/pipe3_hazard_ctrl.sv
module pipe3_hazard_ctrl
    import pipe3_pkg::*;
#(
    parameter int unsigned     XLEN      = 32,
    parameter int unsigned     NREG      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000,
    parameter int unsigned     INSN_B    = 4,
    parameter bit              WB_BYPASS = 1'b0,
    localparam int unsigned    RIDX_W    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] fd_rs1,
    input  logic              fd_rs1_used,
    input  logic [RIDX_W-1:0] fd_rs2,
    input  logic              fd_rs2_used,
    input  logic [RIDX_W-1:0] fd_rd,
    input  logic              fd_rd_we,
    input  logic              ex_redirect,
    input  logic [XLEN-1:0]   ex_target,
    output logic [XLEN-1:0]   pc,
    output logic [1:0]        pc_sel,
    output logic              fd_stall,
    output logic              fd_flush,
    output logic              ex_valid,
    output logic              wb_we,
    output logic [RIDX_W-1:0] wb_rd
);

    logic [NSRC-1:0]   src_used;
    logic [RIDX_W-1:0] src_idx [NSRC];
    logic [NSRC-1:0]   src_hit;

    logic              ex_v, ex_we, mw_v, mw_we;
    logic [RIDX_W-1:0] ex_rd, mw_rd;

    logic              redirect;
    logic              hazard;
    logic              issue_v;
    pc_sel_e           sel;

    assign src_idx[0] = fd_rs1;
    assign src_idx[1] = fd_rs2;
    assign src_used   = {fd_rs2_used, fd_rs1_used};

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            p3_src_hazard #(
                .RIDX_W    (RIDX_W),
                .WB_BYPASS (WB_BYPASS)
            ) u_src (
                .clk     (clk),
                .rst_n   (rst_n),
                .rs      (src_idx[g]),
                .rs_used (src_used[g]),
                .ex_v    (ex_v),
                .ex_rd   (ex_rd),
                .ex_we   (ex_we),
                .mw_v    (mw_v),
                .mw_rd   (mw_rd),
                .mw_we   (mw_we),
                .hit     (src_hit[g])
            );
        end
    endgenerate

    always_comb begin
        redirect = ex_redirect && ex_v;
        hazard   = (|src_hit) && !redirect;
        issue_v  = !redirect && !hazard;
        if (redirect)    sel = PC_REDIR;
        else if (hazard) sel = PC_HOLD;
        else             sel = PC_SEQ;
    end

    p3_stage_track #(
        .RIDX_W (RIDX_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_v  (issue_v),
        .issue_rd (fd_rd),
        .issue_we (fd_rd_we),
        .ex_v     (ex_v),
        .ex_rd    (ex_rd),
        .ex_we    (ex_we),
        .mw_v     (mw_v),
        .mw_rd    (mw_rd),
        .mw_we    (mw_we)
    );

    p3_pc_unit #(
        .XLEN      (XLEN),
        .RESET_VEC (RESET_VEC),
        .STEP      (INSN_B)
    ) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .target (ex_target),
        .pc     (pc)
    );

    assign pc_sel   = sel;
    assign fd_stall = hazard;
    assign fd_flush = redirect;
    assign ex_valid = ex_v;
    assign wb_we    = mw_v && mw_we && (mw_rd != '0);
    assign wb_rd    = mw_rd;

    // R6
    stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fd_stall |=> !ex_valid);

    // R7
    flush_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fd_flush |=> !ex_valid);

    // R8
    flush_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fd_flush |-> !fd_stall);

    // R9
    dead_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_redirect && !ex_valid) |-> !fd_flush);

    // R10
    x0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |-> (wb_rd != '0));

endmodule

// File: tb/tb_pipe3_hazard_ctrl.sv
`timescale 1ns/1ps
module tb_pipe3_hazard_ctrl;

    localparam int unsigned     XLEN = 32;
    localparam int unsigned     RW   = 5;
    localparam logic [XLEN-1:0] RV   = 32'h0000_1000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [RW-1:0]   rs1, rs2, rd;
    logic            u1, u2, we, redir;
    logic [XLEN-1:0] tgt;

    logic [XLEN-1:0] pc, pc_b;
    logic [1:0]      sel, sel_b;
    logic            stall, flush, exv, wbwe;
    logic            stall_b, flush_b, exv_b, wbwe_b;
    logic [RW-1:0]   wbrd, wbrd_b;

    always #2 clk = ~clk;

    pipe3_hazard_ctrl #(.RESET_VEC(RV), .WB_BYPASS(1'b0)) dut (
        .clk(clk), .rst_n(rst_n),
        .fd_rs1(rs1), .fd_rs1_used(u1), .fd_rs2(rs2), .fd_rs2_used(u2),
        .fd_rd(rd), .fd_rd_we(we), .ex_redirect(redir), .ex_target(tgt),
        .pc(pc), .pc_sel(sel), .fd_stall(stall), .fd_flush(flush),
        .ex_valid(exv), .wb_we(wbwe), .wb_rd(wbrd));

    pipe3_hazard_ctrl #(.RESET_VEC(RV), .WB_BYPASS(1'b1)) dut_byp (
        .clk(clk), .rst_n(rst_n),
        .fd_rs1(rs1), .fd_rs1_used(u1), .fd_rs2(rs2), .fd_rs2_used(u2),
        .fd_rd(rd), .fd_rd_we(we), .ex_redirect(redir), .ex_target(tgt),
        .pc(pc_b), .pc_sel(sel_b), .fd_stall(stall_b), .fd_flush(flush_b),
        .ex_valid(exv_b), .wb_we(wbwe_b), .wb_rd(wbrd_b));

    typedef struct {
        logic [XLEN-1:0] pc;
        logic            stall;
        logic            flush;
        logic            exv;
        logic            wbwe;
        logic [RW-1:0]   wbrd;
        logic            chk_byp;
        logic            byp_stall;
        string           tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver side
    task automatic set_in(input logic [RW-1:0] a, input logic ua,
                          input logic [RW-1:0] b, input logic ub,
                          input logic [RW-1:0] d, input logic dw,
                          input logic r, input logic [XLEN-1:0] t);
        rs1 = a; u1 = ua; rs2 = b; u2 = ub; rd = d; we = dw; redir = r; tgt = t;
    endtask

    task automatic expect_out(input logic [XLEN-1:0] p, input logic s, input logic f,
                              input logic v, input logic w, input logic [RW-1:0] wr,
                              input logic cb, input logic bs, input string tag);
        exp_t e;
        e.pc = p; e.stall = s; e.flush = f; e.exv = v; e.wbwe = w; e.wbrd = wr;
        e.chk_byp = cb; e.byp_stall = bs; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // monitor side
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            logic [1:0] esel;
            e = sb.pop_front();
            esel = e.flush ? 2'd2 : (e.stall ? 2'd1 : 2'd0);
            check(pc == e.pc, e.tag, "pc", pc, e.pc);
            check(stall == e.stall, e.tag, "fd_stall", 32'(stall), 32'(e.stall));
            check(flush == e.flush, e.tag, "fd_flush", 32'(flush), 32'(e.flush));
            check(sel == esel, e.tag, "pc_sel", 32'(sel), 32'(esel));
            check(exv == e.exv, e.tag, "ex_valid", 32'(exv), 32'(e.exv));
            check(wbwe == e.wbwe, e.tag, "wb_we", 32'(wbwe), 32'(e.wbwe));
            if (e.wbwe)
                check(wbrd == e.wbrd, e.tag, "wb_rd", 32'(wbrd), 32'(e.wbrd));
            if (e.chk_byp)
                check(stall_b == e.byp_stall, e.tag, "bypass fd_stall",
                      32'(stall_b), 32'(e.byp_stall));
        end
    end

    initial begin
        #(4 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        set_in(0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, first instruction writes x5
        set_in(0, 1, 0, 0, 5, 1, 0, 0);
        expect_out(RV, 0, 0, 0, 0, 0, 0, 0, "R1"); tick();
        // R2: writes x6
        set_in(0, 1, 0, 0, 6, 1, 0, 0);
        expect_out(RV + 4, 0, 0, 1, 0, 0, 0, 0, "R2"); tick();
        // R5: matching indices x5/x6 with used flags clear
        set_in(5, 0, 6, 0, 7, 1, 0, 0);
        expect_out(RV + 8, 0, 0, 1, 1, 5, 0, 0, "R5"); tick();
        // R4: reads x6 sitting in write-back; bypass instance does not stall
        set_in(6, 1, 0, 0, 8, 1, 0, 0);
        expect_out(RV + 12, 1, 0, 1, 1, 6, 1, 0, "R4"); tick();
        // R6: one stall cycle only for a write-back dependency
        expect_out(RV + 12, 0, 0, 0, 1, 7, 0, 0, "R6"); tick();
        // R3: reads x8 held by execute
        set_in(0, 0, 8, 1, 11, 1, 0, 0);
        expect_out(RV + 16, 1, 0, 1, 0, 0, 0, 0, "R3"); tick();
        // R6: second stall cycle as producer moves to write-back
        expect_out(RV + 16, 1, 0, 0, 1, 8, 0, 0, "R6"); tick();
        // R6: released after exactly two
        expect_out(RV + 16, 0, 0, 0, 0, 0, 0, 0, "R6"); tick();
        // R2: branch reading x0
        set_in(0, 1, 0, 1, 0, 0, 0, 0);
        expect_out(RV + 20, 0, 0, 1, 0, 0, 0, 0, "R2"); tick();
        // R8: branch redirects while wrong-path reads x11 in write-back
        set_in(11, 1, 0, 0, 10, 1, 1, 32'h2000);
        expect_out(RV + 24, 0, 1, 1, 1, 11, 0, 0, "R8"); tick();
        // R7: target fetched next cycle, execute holds a bubble
        set_in(0, 0, 0, 0, 0, 1, 0, 0);
        expect_out(32'h2000, 0, 0, 0, 0, 0, 0, 0, "R7"); tick();
        // R5: x0 destination in execute, reads of x0 do not stall
        set_in(0, 1, 0, 1, 12, 1, 0, 0);
        expect_out(32'h2004, 0, 0, 1, 0, 0, 0, 0, "R5"); tick();
        // R10: jump redirects; write-back holds x0 write, must not enable
        set_in(0, 0, 0, 0, 13, 1, 1, 32'h3000);
        expect_out(32'h2008, 0, 1, 1, 0, 0, 0, 0, "R10"); tick();
        // R9 / R7: redirect with execute empty ignored; flushed x13 never stalls
        set_in(13, 1, 0, 0, 14, 1, 1, 32'h5000);
        expect_out(32'h3000, 0, 0, 0, 1, 12, 0, 0, "R9"); tick();
        // R9: sequential pc confirms ignored redirect
        set_in(0, 0, 0, 0, 0, 0, 0, 0);
        expect_out(32'h3004, 0, 0, 1, 0, 0, 0, 0, "R9"); tick();
        // R10: x14 reaches write-back
        set_in(0, 0, 0, 0, 15, 1, 0, 0);
        expect_out(32'h3008, 0, 0, 1, 1, 14, 0, 0, "R10"); tick();
        // R2
        set_in(0, 0, 0, 0, 0, 0, 0, 0);
        expect_out(32'h300c, 0, 0, 1, 0, 0, 0, 0, "R2"); tick();

        // R1: reset in mid-run
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        expect_out(RV, 0, 0, 0, 0, 0, 0, 0, "R1"); tick();
        expect_out(RV + 4, 0, 0, 1, 0, 0, 0, 0, "R2"); tick();

        @(negedge clk);
        #1;
        check(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule